// File: doc/BRIEF.md
# Serial Configuration Word Loader

This block is a three-wire write-only programming port for a bank of control registers. A host drives a serial clock, a serial data line and a load strobe. Each rising edge of the serial clock pushes one data bit into a word-wide shift register, most significant bit first. When the load strobe rises, the whole shifted word is copied into one of the holding registers. The register is chosen by the lowest address bits of that same word. The copied word keeps those address bits.

All three serial lines and the chip-enable line are treated as asynchronous. Each passes through a synchronizer into the system clock domain, and edges are found there. While chip enable is low, every holding register and its valid flag are cleared, loads are ignored and the shift register is held at zero. After chip enable returns, each register must be programmed again before its valid flag comes back.

Top module: `cfg_serial_loader`

## Requirements
- R1: While reset is asserted and directly after it, every register word reads zero and every valid flag is zero.
- R2: Each synchronized rising edge of `ser_clk_i` shifts the sampled `ser_dat_i` into bit 0 of the shift register, moving older bits toward the MSB. A word is therefore sent MSB first.
- R3: On a load, the full shifted word, including its two address bits, is stored in register N, where N is word bits [1:0] (0 to 3). Register N occupies `reg_word_o[32*N+31:32*N]`. The other registers keep their values.
- R4: Exactly one register update happens per rising edge of `ser_ld_i`. Holding the strobe high, or shifting bits while it is high, causes no further update.
- R5: If a number of serial clock edges other than 32 comes before a load, the stored word is the last 32 bits shifted in. With fewer than 32 new bits, the upper bits are the older shift-register contents.
- R6: `reg_valid_o[N]` goes to 1 in the same cycle that register N is written, and it stays at 1 until chip enable drops.
- R7: While synchronized chip enable is low, all words and valid flags are cleared, loads have no effect, and the shift register is held at zero. After chip enable returns, a word shorter than 32 bits therefore has zero upper bits.
- R8: An input change that is present before system clock edge k takes effect at edge k+2, through the two synchronizer stages. A load strobe rising before edge k updates the register at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial bit clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data bit (asynchronous) |
| ser_ld_i | input | 1 | Load strobe; its rising edge commits the word |
| chip_en_i | input | 1 | Chip enable; low clears the whole bank |
| reg_word_o | output | 128 | Four 32-bit register words, register N at bits 32*N+31:32*N |
| reg_valid_o | output | 4 | Per-register written-since-enable flag |

## Verification
Every input change reaches the outputs on the second system clock edge after it is sampled. This holds for a shift, a load or a chip-enable clear. The bench reference model keeps a short queue of sampled input levels and acts on the entry two edges old, so its comparison at each falling edge matches the design's timing with no slack. Directed checks on known words read the outputs only after the strobe has settled. One check samples the falling edges just before and just after the due edge for a load, to confirm the two-edge delay.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

   localparam int DEF_WORD_W   = 32;
   localparam int DEF_NUM_REGS = 4;
   localparam int DEF_SYNC     = 2;

   // the four asynchronous control lines, carried together through the synchronizer
   typedef struct packed {
      logic ce;
      logic ld;
      logic dat;
      logic sclk;
   } cfgld_lines_t;

   localparam int LINES_W = $bits(cfgld_lines_t);

endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cfgld_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= '0;
      end else begin
         stg[0] <= d_i;
         for (int s = 1; s < STAGES; s++) begin
            stg[s] <= stg[s-1];
         end
      end
   end

   assign q_o = stg[STAGES-1];

endmodule

// File: rtl/cfgld_edge.sv
module cfgld_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o
);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~prev_q;

endmodule

// File: rtl/cfgld_shifter.sv
module cfgld_shifter #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              shift_i,
   input  logic              bit_i,
   output logic [WORD_W-1:0] word_o
);

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("cfgld_shifter: WORD_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_o <= '0;
      else if (clr_i)   word_o <= '0;
      else if (shift_i) word_o <= {word_o[WORD_W-2:0], bit_i};
   end

endmodule

// File: rtl/cfgld_bank.sv
module cfgld_bank #(
   parameter int WORD_W   = 32,
   parameter int NUM_REGS = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr_i,
   input  logic                       load_i,
   input  logic [WORD_W-1:0]          word_i,
   output logic [NUM_REGS-1:0]        wr_en_o,
   output logic [NUM_REGS*WORD_W-1:0] words_o,
   output logic [NUM_REGS-1:0]        valid_o
);

   localparam int ADDR_W = $clog2(NUM_REGS);

   logic [ADDR_W-1:0] sel;
   assign sel = word_i[ADDR_W-1:0];

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         logic [WORD_W-1:0] q;
         logic              v;

         assign wr_en_o[i] = load_i && (sel == ADDR_W'(i));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
               v <= 1'b0;
            end else if (clr_i) begin
               q <= '0;
               v <= 1'b0;
            end else if (wr_en_o[i]) begin
               q <= word_i;
               v <= 1'b1;
            end
         end

         assign words_o[i*WORD_W +: WORD_W] = q;
         assign valid_o[i]                  = v;
      end
   endgenerate

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
   import cfgld_pkg::*;
#(
   parameter int WORD_W   = DEF_WORD_W,
   parameter int NUM_REGS = DEF_NUM_REGS,
   parameter int SYNC     = DEF_SYNC
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ser_clk_i,
   input  logic                       ser_dat_i,
   input  logic                       ser_ld_i,
   input  logic                       chip_en_i,
   output logic [NUM_REGS*WORD_W-1:0] reg_word_o,
   output logic [NUM_REGS-1:0]        reg_valid_o
);

   localparam int ADDR_W = $clog2(NUM_REGS);

   generate
      if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
         $error("cfg_serial_loader: NUM_REGS must be a power of two, at least 2");
      end
      if (WORD_W <= ADDR_W) begin : g_bad_word
         $error("cfg_serial_loader: WORD_W must exceed the address width");
      end
   endgenerate

   cfgld_lines_t lines_raw, lines_s;
   logic         sclk_rise;
   logic         ld_rise;
   logic         ce_q;
   logic         load_pulse;
   logic [WORD_W-1:0]   shift_word;
   logic [NUM_REGS-1:0] wr_en;

   assign lines_raw = '{ce: chip_en_i, ld: ser_ld_i, dat: ser_dat_i, sclk: ser_clk_i};

   cfgld_sync #(.W(LINES_W), .STAGES(SYNC)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (lines_raw),
      .q_o   (lines_s)
   );

   cfgld_edge u_sclk_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (lines_s.sclk),
      .rise_o (sclk_rise)
   );

   cfgld_edge u_ld_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (lines_s.ld),
      .rise_o (ld_rise)
   );

   assign ce_q       = lines_s.ce;
   assign load_pulse = ld_rise & ce_q;

   cfgld_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (~ce_q),
      .shift_i (sclk_rise),
      .bit_i   (lines_s.dat),
      .word_o  (shift_word)
   );

   cfgld_bank #(.WORD_W(WORD_W), .NUM_REGS(NUM_REGS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (~ce_q),
      .load_i  (load_pulse),
      .word_i  (shift_word),
      .wr_en_o (wr_en),
      .words_o (reg_word_o),
      .valid_o (reg_valid_o)
   );

endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker #(
   parameter int WORD_W   = 32,
   parameter int NUM_REGS = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       ce_q,
   input logic                       load_pulse,
   input logic [NUM_REGS-1:0]        wr_en,
   input logic [WORD_W-1:0]          shift_word,
   input logic [NUM_REGS*WORD_W-1:0] reg_word_o,
   input logic [NUM_REGS-1:0]        reg_valid_o
);

   localparam int ADDR_W = $clog2(NUM_REGS);

   // R3: at most one register is written per cycle
   p_single_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_en));

   // R7: a low enable clears all flags and the shift register on the next edge
   p_ce_clears_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_q |=> (reg_valid_o == '0));

   p_ce_clears_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_q |=> (shift_word == '0));

   // R6: a flag can only rise after an accepted load
   p_valid_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|(reg_valid_o & ~$past(reg_valid_o))) |-> $past(load_pulse && ce_q));

   // R4: without a load the stored words do not move
   p_hold_no_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_pulse && ce_q) |=> $stable(reg_word_o));

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
         // R3: the addressed register receives the whole shifted word
         p_word_stored_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (load_pulse && ce_q && shift_word[ADDR_W-1:0] == ADDR_W'(i))
            |=> (reg_word_o[i*WORD_W +: WORD_W] == $past(shift_word)));
      end
   endgenerate

endmodule

bind cfg_serial_loader cfgld_checker #(.WORD_W(WORD_W), .NUM_REGS(NUM_REGS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ce_q        (ce_q),
   .load_pulse  (load_pulse),
   .wr_en       (wr_en),
   .shift_word  (shift_word),
   .reg_word_o  (reg_word_o),
   .reg_valid_o (reg_valid_o)
);

// File: tb/sim_cfg_serial_loader.sv
module sim_cfg_serial_loader;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sclk = 1'b0, sdat = 1'b0, sld = 1'b0, ce = 1'b0;
   logic [127:0] words;
   logic [3:0]   valid;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   cfg_serial_loader u0 (
      .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat),
      .ser_ld_i(sld), .chip_en_i(ce), .reg_word_o(words), .reg_valid_o(valid)
   );

   // ---------------- reference model: acts on inputs seen two edges ago
   typedef struct packed { logic ce; logic ld; logic dat; logic sclk; } smp_t;
   smp_t        hist[$];
   logic [31:0] m_shift;
   logic [31:0] m_word [4];
   logic [3:0]  m_valid;

   initial begin
      for (int i = 0; i < 4; i++) hist.push_back('0);
      m_shift = '0; m_valid = '0;
      for (int i = 0; i < 4; i++) m_word[i] = '0;
   end

   always @(posedge clk) begin
      smp_t now2, now3;
      logic [31:0] old;
      hist.push_back(rst_n ? smp_t'({ce, sld, sdat, sclk}) : smp_t'('0));
      hist.pop_front();
      now2 = hist[1];
      now3 = hist[0];
      if (!rst_n || !now2.ce) begin
         m_shift = '0; m_valid = '0;
         for (int i = 0; i < 4; i++) m_word[i] = '0;
      end else begin
         old = m_shift;
         if (now2.sclk && !now3.sclk) m_shift = {m_shift[30:0], now2.dat};
         if (now2.ld && !now3.ld) begin
            m_word[old[1:0]]  = old;
            m_valid[old[1:0]] = 1'b1;
         end
      end
   end

   always @(negedge clk) if (!done) begin
      for (int i = 0; i < 4; i++) begin
         checks++;
         if (words[i*32 +: 32] !== m_word[i]) begin
            errors++;
            $display("FAIL R3 model reg%0d actual %h expected %h", i, words[i*32 +: 32], m_word[i]);
         end
      end
      checks++;
      if (valid !== m_valid) begin
         errors++;
         $display("FAIL R6 model valid actual %b expected %b", valid, m_valid);
      end
   end

   // ---------------- directed helpers
   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic shift_bits(input logic [63:0] v, input int n);
      for (int b = n - 1; b >= 0; b--) begin
         sdat = v[b]; tick(2);
         sclk = 1'b1; tick(3);
         sclk = 1'b0; tick(3);
      end
   endtask

   task automatic pulse_load();
      sld = 1'b1; tick(4);
      sld = 1'b0; tick(4);
   endtask

   task automatic chk_word(input int idx, input logic [31:0] exp, input string tag);
      checks++;
      if (words[idx*32 +: 32] !== exp) begin
         errors++;
         $display("FAIL %s reg%0d actual %h expected %h", tag, idx, words[idx*32 +: 32], exp);
      end
   endtask

   task automatic chk_valid(input logic [3:0] exp, input string tag);
      checks++;
      if (valid !== exp) begin
         errors++;
         $display("FAIL %s valid actual %b expected %b", tag, valid, exp);
      end
   endtask

   initial begin
      tick(3);
      // R1: reset state
      for (int i = 0; i < 4; i++) chk_word(i, 32'h0, "R1");
      chk_valid(4'b0000, "R1");
      rst_n = 1'b1; ce = 1'b1; tick(4);
      for (int i = 0; i < 4; i++) chk_word(i, 32'h0, "R1");

      // R2 and R3: one word into each register
      shift_bits(64'h12345678, 32); pulse_load();
      chk_word(0, 32'h12345678, "R2");
      chk_valid(4'b0001, "R6");
      shift_bits(64'hCAFEF00D, 32); pulse_load();
      chk_word(1, 32'hCAFEF00D, "R3");
      chk_word(0, 32'h12345678, "R3");
      shift_bits(64'h0BADBEE2, 32); pulse_load();
      shift_bits(64'h76543213, 32); pulse_load();
      chk_word(2, 32'h0BADBEE2, "R3");
      chk_word(3, 32'h76543213, "R3");
      chk_valid(4'b1111, "R6");

      // R4: strobe held high while a new word is shifted
      sld = 1'b1; tick(4);
      chk_word(3, 32'h76543213, "R4");
      shift_bits(64'hFFFFFFF0, 32);
      chk_word(0, 32'h12345678, "R4");
      sld = 1'b0; tick(4);
      pulse_load();
      chk_word(0, 32'hFFFFFFF0, "R4");

      // R5: too many bits, then too few
      shift_bits(64'h000000AB11223345, 40); pulse_load();
      chk_word(1, 32'h11223345, "R5");
      shift_bits(64'h9E, 8); pulse_load();
      chk_word(2, 32'h2233459E, "R5");

      // R7: enable low wipes everything, loads ignored
      ce = 1'b0; tick(4);
      for (int i = 0; i < 4; i++) chk_word(i, 32'h0, "R7");
      chk_valid(4'b0000, "R7");
      shift_bits(64'hFFFFFFFF, 4); pulse_load();
      chk_valid(4'b0000, "R7");
      ce = 1'b1; tick(4);
      shift_bits(64'hBEEF, 16); pulse_load();
      chk_word(3, 32'h0000BEEF, "R7");
      chk_valid(4'b1000, "R7");

      // R8: load lands on the second edge after the strobe is sampled
      shift_bits(64'h55AA33C1, 32);
      sld = 1'b1;
      tick(1);
      tick(1);
      chk_word(1, 32'h0, "R8");
      tick(1);
      chk_word(1, 32'h55AA33C1, "R8");
      sld = 1'b0; tick(4);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule